// File: doc/BRIEF.md
# Cascaded BCD Decade Counter

This block is a chain of synchronous decimal digits, each a four-bit register that steps through the codes 0 to 9 and then returns to 0. A whole chain can be preset from a parallel input in one clock edge. It can be cleared at any moment, without a clock edge, by pulling an active-low clear input low. Each digit has two active-high count enables. The first enable is shared by every digit and acts as a global run or stop control. The second enable, the trickle enable, is driven for digit 0 from a top-level input, and for every higher digit from the terminal-count signal of the digit below it.

A digit raises its terminal-count signal while it holds 9 and its trickle enable is high. The digit above therefore advances for exactly one edge each time the lower digit wraps. The terminal count of the top digit leaves the block as a carry, so that more chains can be added above it. The number of digits is a parameter.

Top module: `bcd_decade_chain`

## Requirements
- R1: While `clr_n` is low, `count` and every bit of `tc_vec` are 0. This takes effect at once, with no clock edge, and holds through any clock edges that arrive while `clr_n` stays low.
- R2: At a rising edge with `clr_n` high and `load_n` low, every digit takes its slice of `preset`, whatever `cnt_en` and `chain_en` are. Digit k occupies bits [4k+3:4k] of both `preset` and `count`.
- R3: At a rising edge with `load_n` high, `cnt_en` high and the digit's trickle enable high, a digit that holds 0 to 8 goes up by one and a digit that holds 9 goes to 0.
- R4: At a rising edge with `load_n` high and `cnt_en` low, every digit keeps its value.
- R5: At a rising edge with `load_n` high and the digit's trickle enable low, that digit keeps its value. With `chain_en` low, the whole chain holds.
- R6: `tc_vec[k]` is high exactly when digit k holds 9 (binary 1001) and its trickle enable is high. It does not depend on `cnt_en`.
- R7: A digit loaded with an illegal code (10 to 15) never raises its terminal count. It goes to 0 at its next counting edge.
- R8: The trickle enable of digit 0 is `chain_en`, and the trickle enable of digit k+1 is `tc_vec[k]`. `carry_out` equals the top bit of `tc_vec`. A chain that holds all nines goes to all zeros in one counting edge.
- R9: While `clr_n` is high, `count` changes only at a rising edge of `clk`. A change of `load_n` or `preset` between edges leaves it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loading and counting happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low; takes priority over counting |
| cnt_en | input | 1 | Global count enable shared by all digits |
| chain_en | input | 1 | Trickle enable of digit 0 |
| preset | input | 4*NUM_DECADES | Parallel load value, one BCD digit per nibble |
| count | output | 4*NUM_DECADES | Present value, one BCD digit per nibble |
| tc_vec | output | NUM_DECADES | Terminal count of each digit |
| carry_out | output | 1 | Terminal count of the top digit |

## Verification
The bench builds the chain with the default of three decades. With three decades a middle digit can be observed. That digit's trickle enable comes from below and its terminal count drives the digit above, so an illegal code loaded into it tests its wrap rule while it is being fed by the chain. Three decades also keep a complete 000 to 999 to 000 sweep down to 1000 edges. Every digit then wraps many times, and the carry ripples across both links of the chain, including the single edge on which all three digits go to zero together.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t LAST_DIGIT = digit_t'(9);

  // Successor in decimal order; any code at or beyond 9 returns to 0.
  function automatic digit_t digit_succ(digit_t d);
    return (d >= LAST_DIGIT) ? '0 : digit_t'(d + 1'b1);
  endfunction

  function automatic logic digit_is_last(digit_t d);
    return d == LAST_DIGIT;
  endfunction
endpackage

// File: rtl/bcd_digit_next.sv
module bcd_digit_next
  import bcd_cnt_pkg::*;
(
  input  digit_t cur,
  input  digit_t preset,
  input  logic   load_n,
  input  logic   pe,
  input  logic   te,
  output digit_t nxt,
  output logic   advance,
  output logic   tc
);
  always_comb begin
    advance = load_n && pe && te;
    tc      = te && digit_is_last(cur);
    if (!load_n)      nxt = preset;
    else if (advance) nxt = digit_succ(cur);
    else              nxt = cur;
  end
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   clr_n,
  input  logic   load_n,
  input  logic   pe,
  input  logic   te,
  input  digit_t preset,
  output digit_t q,
  output logic   advance,
  output logic   tc
);
  digit_t nxt;

  bcd_digit_next u_next (
    .cur     (q),
    .preset  (preset),
    .load_n  (load_n),
    .pe      (pe),
    .te      (te),
    .nxt     (nxt),
    .advance (advance),
    .tc      (tc)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/bcd_decade_chain.sv
module bcd_decade_chain
  import bcd_cnt_pkg::*;
#(
  parameter int NUM_DECADES = 3
) (
  input  logic                           clk,
  input  logic                           clr_n,
  input  logic                           load_n,
  input  logic                           cnt_en,
  input  logic                           chain_en,
  input  logic [NUM_DECADES*DIGIT_W-1:0] preset,
  output logic [NUM_DECADES*DIGIT_W-1:0] count,
  output logic [NUM_DECADES-1:0]         tc_vec,
  output logic                           carry_out
);
  localparam int VEC_W = NUM_DECADES * DIGIT_W;

  // te_chain[k] is the trickle enable of digit k; te_chain[k+1] is its terminal count.
  logic [NUM_DECADES:0]   te_chain;
  logic [NUM_DECADES-1:0] stage_adv;
  logic [VEC_W-1:0]       count_q;

  assign te_chain[0] = chain_en;

  for (genvar k = 0; k < NUM_DECADES; k++) begin : g_digit
    bcd_digit_stage u_stage (
      .clk     (clk),
      .clr_n   (clr_n),
      .load_n  (load_n),
      .pe      (cnt_en),
      .te      (te_chain[k]),
      .preset  (preset[k*DIGIT_W +: DIGIT_W]),
      .q       (count_q[k*DIGIT_W +: DIGIT_W]),
      .advance (stage_adv[k]),
      .tc      (te_chain[k+1])
    );
  end

  assign count     = count_q;
  assign tc_vec    = te_chain[NUM_DECADES:1];
  assign carry_out = te_chain[NUM_DECADES];
endmodule

// File: rtl/bcd_decade_chain_chk.sv
module bcd_decade_chain_chk
  import bcd_cnt_pkg::*;
#(
  parameter int NUM_DECADES = 3
) (
  input logic                           clk,
  input logic                           clr_n,
  input logic                           load_n,
  input logic                           cnt_en,
  input logic                           chain_en,
  input logic [NUM_DECADES*DIGIT_W-1:0] preset,
  input logic [NUM_DECADES*DIGIT_W-1:0] count,
  input logic [NUM_DECADES-1:0]         tc_vec,
  input logic                           carry_out,
  input logic [NUM_DECADES:0]           te_chain,
  input logic [NUM_DECADES-1:0]         stage_adv
);
  assert_clear_R1: assert property (@(posedge clk)
    !clr_n |-> (count == '0 && tc_vec == '0));

  assert_carry_R8: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == tc_vec[NUM_DECADES-1]);

  assert_chain_root_R8: assert property (@(posedge clk) disable iff (!clr_n)
    te_chain[0] == chain_en);

  for (genvar k = 0; k < NUM_DECADES; k++) begin : g_chk
    assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> count[k*DIGIT_W +: DIGIT_W] == $past(preset[k*DIGIT_W +: DIGIT_W]));

    assert_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
      stage_adv[k] |=> count[k*DIGIT_W +: DIGIT_W]
                       == digit_succ($past(count[k*DIGIT_W +: DIGIT_W])));

    assert_hold_pe_R4: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !cnt_en) |=> $stable(count[k*DIGIT_W +: DIGIT_W]));

    assert_hold_te_R5: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !te_chain[k]) |=> $stable(count[k*DIGIT_W +: DIGIT_W]));

    assert_tc_R6: assert property (@(posedge clk) disable iff (!clr_n)
      tc_vec[k] |-> (te_chain[k] && count[k*DIGIT_W +: DIGIT_W] == LAST_DIGIT));

    assert_legal_after_count_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cnt_en && te_chain[k]) |=> count[k*DIGIT_W +: DIGIT_W] <= LAST_DIGIT);
  end
endmodule

bind bcd_decade_chain bcd_decade_chain_chk #(.NUM_DECADES(NUM_DECADES)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .chain_en  (chain_en),
  .preset    (preset),
  .count     (count),
  .tc_vec    (tc_vec),
  .carry_out (carry_out),
  .te_chain  (te_chain),
  .stage_adv (stage_adv)
);

// File: tb/tb_bcd_decade_chain.sv
module tb_bcd_decade_chain;
  localparam int ND = 3;
  localparam int W  = ND * 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          clr_n, load_n, cnt_en, chain_en;
  logic [W-1:0]  preset;
  wire  [W-1:0]  count;
  wire  [ND-1:0] tc_vec;
  wire           carry_out;

  int n_chk = 0;
  int n_fail = 0;
  int model [ND];
  bit done = 1'b0;

  bcd_decade_chain #(.NUM_DECADES(ND)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .preset(preset), .count(count),
    .tc_vec(tc_vec), .carry_out(carry_out)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_count();
    logic [W-1:0] v;
    for (int k = 0; k < ND; k++) v[k*4 +: 4] = 4'(model[k]);
    return v;
  endfunction

  function automatic logic [ND-1:0] exp_tc();
    logic [ND-1:0] t;
    logic en = chain_en;
    for (int k = 0; k < ND; k++) begin
      t[k] = en && (model[k] == 9);
      en = t[k];
    end
    return t;
  endfunction

  task automatic check_all(string req);
    logic [ND-1:0] t;
    t = exp_tc();
    chk(req, "count", 32'(count), 32'(exp_count()));
    chk(req, "tc_vec", 32'(tc_vec), 32'(t));
    chk(req, "carry_out", 32'(carry_out), 32'(t[ND-1]));
  endtask

  // Reference model of one rising edge, from the written requirements.
  task automatic model_edge();
    if (!clr_n) begin
      for (int k = 0; k < ND; k++) model[k] = 0;
    end else if (!load_n) begin
      for (int k = 0; k < ND; k++) model[k] = int'(preset[k*4 +: 4]);
    end else if (cnt_en) begin
      logic en = chain_en;
      for (int k = 0; k < ND; k++) begin
        logic nxt_en = en && (model[k] == 9);
        if (en) model[k] = (model[k] >= 9) ? 0 : model[k] + 1;
        en = nxt_en;
      end
    end
  endtask

  task automatic clock_edge(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(req);
  endtask

  task automatic do_load(logic [W-1:0] v, string req);
    load_n = 1'b0; preset = v;
    clock_edge(req);
    load_n = 1'b1;
  endtask

  task automatic t_reset();
    clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; preset = '0;
    #1 clr_n = 1'b0;
    for (int k = 0; k < ND; k++) model[k] = 0;
    #2 check_all("R1");
    clock_edge("R1");
    clr_n = 1'b1;
  endtask

  task automatic t_load_with_enables();
    cnt_en = 1'b1; chain_en = 1'b1;
    load_n = 1'b0; preset = 12'h456;
    #4 check_all("R9");
    clock_edge("R2");
    load_n = 1'b1; preset = 12'h321;
    #4 check_all("R9");
  endtask

  task automatic t_count();
    cnt_en = 1'b1; chain_en = 1'b1;
    for (int i = 0; i < 6; i++) clock_edge("R3");
    for (int i = 0; i < 8; i++) clock_edge("R8");
  endtask

  task automatic t_hold();
    cnt_en = 1'b0; chain_en = 1'b1;
    for (int i = 0; i < 3; i++) clock_edge("R4");
    cnt_en = 1'b1; chain_en = 1'b0;
    for (int i = 0; i < 3; i++) clock_edge("R5");
  endtask

  task automatic t_tc();
    cnt_en = 1'b1; chain_en = 1'b1;
    do_load(12'h099, "R2");
    cnt_en = 1'b0;
    #2 check_all("R6");
    chk("R6", "tc_vec pe low", 32'(tc_vec), 32'h3);
    chain_en = 1'b0;
    #2 check_all("R6");
    chk("R6", "tc_vec te low", 32'(tc_vec), 32'h0);
    chain_en = 1'b1;
  endtask

  task automatic t_illegal();
    cnt_en = 1'b0; chain_en = 1'b1;
    do_load(12'h0FC, "R7");
    chk("R7", "tc on illegal", 32'(tc_vec), 32'h0);
    cnt_en = 1'b1;
    clock_edge("R7");
    chk("R7", "digit0 wrap", 32'(count), 32'h0F0);
    cnt_en = 1'b0;
    do_load(12'h0F9, "R7");
    cnt_en = 1'b1;
    clock_edge("R7");
    chk("R7", "digit1 wrap", 32'(count), 32'h000);
  endtask

  task automatic t_midclear();
    cnt_en = 1'b1; chain_en = 1'b1;
    do_load(12'h578, "R2");
    #5 clr_n = 1'b0;
    for (int k = 0; k < ND; k++) model[k] = 0;
    #2 check_all("R1");
    load_n = 1'b0; preset = 12'h777;
    clock_edge("R1");
    load_n = 1'b1;
    clr_n = 1'b1;
    #2 check_all("R1");
  endtask

  task automatic t_rollover();
    cnt_en = 1'b1; chain_en = 1'b1;
    do_load(12'h000, "R2");
    for (int i = 0; i < 999; i++) clock_edge("R8");
    chk("R8", "all nines", 32'(count), 32'h999);
    chk("R8", "carry at 999", 32'(carry_out), 32'h1);
    clock_edge("R8");
    chk("R8", "wrap to zero", 32'(count), 32'h000);
  endtask

  initial begin
    t_reset();
    t_load_with_enables();
    t_count();
    t_hold();
    t_tc();
    t_illegal();
    t_midclear();
    t_rollover();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule